// File: doc/BRIEF.md
# Host Serial Register Port

This block is the host-facing serial access port of a filter and converter core. An external host drives an active-low chip select, a read/write direction line, a register-select line and a serial clock, and it exchanges bits through separate data-in and data-out pins. A read shifts out either a 24-bit conversion word or a 16-bit status word, most significant bit first. A write shifts in one 8-bit configuration byte, which lands in the configuration register. The serial output is enabled only while a read is in progress, so the data-in and data-out pins can share one wire.

All host pins are brought into the system clock domain through two-flop synchronizers. Every edge decision is made there, so the host clock may run at any rate that leaves each serial clock phase a few system clocks long. The two words offered for reading are supplied from outside and are captured when a read begins. The port emits one-cycle progress pulses that let the status logic see a data read being attempted, a data read that reaches its last bit, and a status read being taken. A mode input chooses whether the control outputs come straight from the device pins or from the configuration register.

Top module: `hostser_port`

## Requirements
- R1: With `cs_n` low and `rd_wr` high a read is active. `reg_sel` high selects the 24-bit `data_word`, and low selects the 16-bit `stat_word`. The selected word is captured when the read starts and is sent on `sdo` most significant bit first.
- R2: The first bit is on `sdo` with `sdo_oe` high no later than 4 `clk` cycles after `cs_n` falls. Each later bit appears after an `sck` rising edge that follows the first `sck` falling edge of the read. A rising edge seen before the first falling edge does not advance the bit.
- R3: Once every bit of the word has been sent, further clocks give 0 on a data read and keep repeating bit 0 of the word on a status read.
- R4: Ending a read early (`cs_n` high) discards its position. The next read starts again at the most significant bit and sends the same word.
- R5: `sdo_oe` is high only while a read is active. It falls within 4 `clk` cycles of `cs_n` rising. `sdo` is 0 whenever `sdo_oe` is low.
- R6: With `cs_n` low and `rd_wr` low a write is active. `sdi` is sampled on each `sck` falling edge, and the first bit goes to configuration bit 7 and the eighth to bit 0. The fields, from bit 7 down to bit 0, are power-down, calibrate, use-offset, channel-select, reserved, rate C, rate B and rate A. The byte is committed as soon as the eighth bit arrives, while `cs_n` is still low. Falling edges after the eighth are ignored.
- R7: A write that ends with fewer than 8 bits still commits at its end. Configuration bits that were not received keep their previous values, so a write with no clocks leaves the register unchanged.
- R8: The reserved configuration bit (bit 3) is always stored and reported as 0, whatever is written.
- R9: With `hw_mode` high `ctrl_o` equals `pin_ctrl`. With `hw_mode` low `ctrl_o` equals the configuration register `cfg_o`.
- R10: During reset the configuration register loads `pin_ctrl` with bit 3 cleared. `sdo_oe`, `sdo` and all progress pulses are 0.
- R11: `rd_data_first` pulses for one cycle on the first `sck` falling edge of a data read. `rd_data_last` pulses on the falling edge that samples bit 0 of a data read. `rd_stat_first` pulses on the first falling edge of a status read. Each pulse occurs at most once per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| reg_sel | input | 1 | Read source: 1 data word, 0 status word |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data in, sampled on sck falling edges |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (high during a read) |
| data_word | input | DATA_W | Conversion word offered for reading |
| stat_word | input | STAT_W | Status word offered for reading |
| hw_mode | input | 1 | 1: pins control the device, 0: configuration register |
| pin_ctrl | input | 8 | Control values from device pins, same field layout as cfg_o |
| cfg_o | output | 8 | Configuration register contents |
| ctrl_o | output | 8 | Effective control fields |
| rd_data_first | output | 1 | Pulse: data read attempted (first falling edge) |
| rd_data_last | output | 1 | Pulse: data read reached bit 0 |
| rd_stat_first | output | 1 | Pulse: status read taken (first falling edge) |

## Verification
The assertions assume that the host changes `rd_wr` and `reg_sel` only while `cs_n` is high. They also assume that `sdi` is stable around each `sck` falling edge, and that every `sck` high and low phase lasts at least three system clocks, so that the synchronizers see each edge once. The stimulus holds every serial clock phase for eight system clocks and changes `sdi` in the middle of the high phase. It changes direction and source only with chip select released and gives the synchronizers two idle cycles between sessions. Under those conditions the bench computes each expected bit, the pulse counts and the committed configuration purely from the requirements.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

   localparam int CFG_BITS = 8;
   localparam int RSVD_POS = 3;

   // configuration fields, bit 7 first on the wire
   typedef struct packed {
      logic       pdn;
      logic       cal;
      logic       ofs_use;
      logic       chan;
      logic       rsvd;
      logic [2:0] rate;
   } cfg_t;

   function automatic cfg_t cfg_clean(input logic [CFG_BITS-1:0] raw);
      cfg_t c;
      c      = cfg_t'(raw);
      c.rsvd = 1'b0;
      return c;
   endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hsp_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hsp_rd.sv
module hsp_rd #(
   parameter int DATA_W = 24,
   parameter int STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              sel_data,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic [DATA_W-1:0] data_in,
   input  logic [STAT_W-1:0] stat_in,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              data_first,
   output logic              data_last,
   output logic              stat_first
);

   localparam int PMAX = (DATA_W > STAT_W) ? DATA_W : STAT_W;
   localparam int PW   = $clog2(PMAX + 1);

   generate
      if (DATA_W < 2 || STAT_W < 2) begin : g_bad_width
         $error("hsp_rd: word widths must be at least 2");
      end
   endgenerate

   logic              busy_q;
   logic              is_data_q;
   logic              seen_fall_q;
   logic [PW-1:0]     ptr_q;
   logic [DATA_W-1:0] snap_d_q;
   logic [STAT_W-1:0] snap_s_q;
   logic [DATA_W-1:0] sh_d;
   logic [STAT_W-1:0] sh_s;
   logic              bit_d;
   logic              bit_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         is_data_q   <= 1'b0;
         seen_fall_q <= 1'b0;
         ptr_q       <= '0;
         snap_d_q    <= '0;
         snap_s_q    <= '0;
         data_first  <= 1'b0;
         data_last   <= 1'b0;
         stat_first  <= 1'b0;
      end else begin
         data_first <= 1'b0;
         data_last  <= 1'b0;
         stat_first <= 1'b0;
         if (!act) begin
            busy_q      <= 1'b0;
            seen_fall_q <= 1'b0;
         end else if (!busy_q) begin
            busy_q      <= 1'b1;
            is_data_q   <= sel_data;
            snap_d_q    <= data_in;
            snap_s_q    <= stat_in;
            ptr_q       <= '0;
            seen_fall_q <= 1'b0;
         end else begin
            if (sck_fall) begin
               seen_fall_q <= 1'b1;
               if (!seen_fall_q) begin
                  if (is_data_q) data_first <= 1'b1;
                  else           stat_first <= 1'b1;
               end
               if (is_data_q && ptr_q == PW'(DATA_W - 1)) data_last <= 1'b1;
            end
            if (sck_rise && seen_fall_q && ptr_q != PW'(PMAX)) ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   // left shift fills with zeros: the data word pads itself
   always_comb begin
      sh_d  = snap_d_q << ptr_q;
      sh_s  = snap_s_q << ptr_q;
      bit_d = sh_d[DATA_W-1];
      bit_s = (ptr_q >= PW'(STAT_W)) ? snap_s_q[0] : sh_s[STAT_W-1];
   end

   assign sdo_oe = busy_q;
   assign sdo    = busy_q & (is_data_q ? bit_d : bit_s);

   // R5
   oe_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> $past(act));

   // R2
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && !seen_fall_q) |-> (ptr_q == '0));

   // R3
   stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && !is_data_q && ptr_q >= PW'(STAT_W)) |=> (!sdo_oe || $stable(sdo)));

   // R3
   data_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && is_data_q && ptr_q >= PW'(DATA_W)) |-> !sdo);

   // R11
   first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_first || stat_first) |-> !$past(seen_fall_q));

endmodule

// File: rtl/hsp_wr.sv
module hsp_wr
   import hsp_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                act,
   input  logic                sck_fall,
   input  logic                sdi,
   input  logic [CFG_BITS-1:0] cur_cfg,
   output logic                commit,
   output logic [CFG_BITS-1:0] commit_val
);

   localparam int CW = $clog2(CFG_BITS + 1);
   localparam int IW = $clog2(CFG_BITS);

   logic                busy_q;
   logic                done_q;
   logic [CW-1:0]       cnt_q;
   logic [CFG_BITS-1:0] hold_q;
   logic [IW-1:0]       wr_idx;

   assign wr_idx = IW'(CFG_BITS - 1) - cnt_q[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         hold_q <= '0;
         commit <= 1'b0;
      end else begin
         commit <= 1'b0;
         if (!act) begin
            if (busy_q && !done_q) commit <= 1'b1;
            busy_q <= 1'b0;
         end else if (!busy_q) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            cnt_q  <= '0;
            hold_q <= cur_cfg;
         end else if (sck_fall && !done_q) begin
            hold_q[wr_idx] <= sdi;
            cnt_q          <= cnt_q + 1'b1;
            if (cnt_q == CW'(CFG_BITS - 1)) begin
               done_q <= 1'b1;
               commit <= 1'b1;
            end
         end
      end
   end

   assign commit_val = hold_q;

   // R6
   early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (!$past(act) || $past(cnt_q) == CW'(CFG_BITS - 1)));

   // R7
   short_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !act && !done_q) |=> commit);

endmodule

// File: rtl/hostser_port.sv
module hostser_port
   import hsp_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int STAT_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_wr,
   input  logic              reg_sel,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic [DATA_W-1:0] data_word,
   input  logic [STAT_W-1:0] stat_word,
   input  logic              hw_mode,
   input  logic [7:0]        pin_ctrl,
   output logic [7:0]        cfg_o,
   output logic [7:0]        ctrl_o,
   output logic              rd_data_first,
   output logic              rd_data_last,
   output logic              rd_stat_first
);

   localparam int NPIN = 5;

   generate
      if (CFG_BITS != 8) begin : g_bad_cfg
         $error("hostser_port: configuration ports are 8 bits wide");
      end
   endgenerate

   logic [NPIN-1:0] pin_raw;
   logic [NPIN-1:0] pin_s;
   logic            cs_s, rw_s, sel_s, sck_s, sdi_s;
   logic            sck_prev_q;
   logic            sck_rise, sck_fall;
   logic            rd_act, wr_act;
   logic            wr_commit;
   logic [7:0]      wr_val;
   cfg_t            cfg_q;

   assign pin_raw = {cs_n, rd_wr, reg_sel, sck, sdi};

   hsp_sync #(
      .WIDTH   (NPIN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (5'b10000)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   assign {cs_s, rw_s, sel_s, sck_s, sdi_s} = pin_s;

   always_ff @(posedge clk) begin
      if (!rst_n) sck_prev_q <= 1'b0;
      else        sck_prev_q <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_prev_q;
   assign sck_fall = ~sck_s & sck_prev_q;
   assign rd_act   = ~cs_s & rw_s;
   assign wr_act   = ~cs_s & ~rw_s;

   hsp_rd #(
      .DATA_W (DATA_W),
      .STAT_W (STAT_W)
   ) rd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (rd_act),
      .sel_data   (sel_s),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .data_in    (data_word),
      .stat_in    (stat_word),
      .sdo        (sdo),
      .sdo_oe     (sdo_oe),
      .data_first (rd_data_first),
      .data_last  (rd_data_last),
      .stat_first (rd_stat_first)
   );

   hsp_wr wr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (wr_act),
      .sck_fall   (sck_fall),
      .sdi        (sdi_s),
      .cur_cfg    (cfg_q),
      .commit     (wr_commit),
      .commit_val (wr_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         cfg_q <= cfg_clean(pin_ctrl);
      else if (wr_commit) cfg_q <= cfg_clean(wr_val);
   end

   assign cfg_o  = cfg_q;
   assign ctrl_o = hw_mode ? pin_ctrl : cfg_q;

   // R5
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdo_oe);

   // R8
   rsvd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_o[RSVD_POS]);

   // R6
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> !$past(rd_act));

endmodule

// File: tb/hostser_port_tb_top.sv
module hostser_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_wr = 1'b1, reg_sel = 1'b1, sck = 1'b1, sdi = 1'b0;
   logic        sdo, sdo_oe;
   logic [23:0] data_word = '0;
   logic [15:0] stat_word = '0;
   logic        hw_mode = 1'b0;
   logic [7:0]  pin_ctrl = 8'hFF;
   logic [7:0]  cfg_o, ctrl_o;
   logic        rd_data_first, rd_data_last, rd_stat_first;

   int total = 0;
   int bad = 0;
   int n_df = 0, n_dl = 0, n_sf = 0;
   bit finished = 1'b0;
   logic [7:0] model_cfg;

   always #2.5 clk = ~clk;

   hostser_port dut_i (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_wr (rd_wr), .reg_sel (reg_sel),
      .sck (sck), .sdi (sdi), .sdo (sdo), .sdo_oe (sdo_oe),
      .data_word (data_word), .stat_word (stat_word), .hw_mode (hw_mode),
      .pin_ctrl (pin_ctrl), .cfg_o (cfg_o), .ctrl_o (ctrl_o),
      .rd_data_first (rd_data_first), .rd_data_last (rd_data_last),
      .rd_stat_first (rd_stat_first)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_data_first) n_df++;
         if (rd_data_last)  n_dl++;
         if (rd_stat_first) n_sf++;
      end
   end

   // row: kind(1: write) | reg_sel | clocks(6) | data(24) | status(16) | write byte(8)
   localparam int NVEC = 12;
   localparam logic [55:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 6'd24, 24'hA5C396, 16'h0000, 8'h00},
      {1'b0, 1'b0, 6'd16, 24'h000000, 16'h8001, 8'h00},
      {1'b0, 1'b1, 6'd30, 24'hFFFFFF, 16'h0000, 8'h00},
      {1'b0, 1'b0, 6'd20, 24'h000000, 16'h4003, 8'h00},
      {1'b0, 1'b0, 6'd20, 24'h000000, 16'h8002, 8'h00},
      {1'b0, 1'b1, 6'd5,  24'h123456, 16'h0000, 8'h00},
      {1'b0, 1'b1, 6'd24, 24'h123456, 16'h0000, 8'h00},
      {1'b1, 1'b0, 6'd8,  24'h000000, 16'h0000, 8'h5A},
      {1'b1, 1'b0, 6'd3,  24'h000000, 16'h0000, 8'hE0},
      {1'b1, 1'b0, 6'd0,  24'h000000, 16'h0000, 8'h00},
      {1'b1, 1'b0, 6'd10, 24'h000000, 16'h0000, 8'h0D},
      {1'b0, 1'b1, 6'd24, 24'h800001, 16'h0000, 8'h00}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic sel, input int n, input logic [23:0] d,
                          input logic [15:0] s, input string lbl);
      int df0, dl0, sf0;
      logic expb;
      string tag;
      df0 = n_df; dl0 = n_dl; sf0 = n_sf;
      data_word = d; stat_word = s; reg_sel = sel; rd_wr = 1'b1;
      tick(2);
      cs_n = 1'b0;
      tick(8);
      chk(sdo_oe === 1'b1, "R5 oe on read", 32'(sdo_oe), 32'd1);
      for (int k = 0; k < n; k++) begin
         if (sel) expb = (k < 24) ? d[23-k] : 1'b0;
         else     expb = (k < 16) ? s[15-k] : s[0];
         tag = ((sel && k >= 24) || (!sel && k >= 16)) ? "R3 pad bit" : lbl;
         chk(sdo === expb, tag, 32'(sdo), 32'(expb));
         sck = 1'b0; tick(8);
         sck = 1'b1; tick(8);
      end
      cs_n = 1'b1;
      tick(8);
      chk(sdo_oe === 1'b0 && sdo === 1'b0, "R5 oe off", {30'd0, sdo_oe, sdo}, 32'd0);
      chk(n_df - df0 == ((sel && n > 0) ? 1 : 0), "R11 data first", 32'(n_df - df0), 32'((sel && n > 0) ? 1 : 0));
      chk(n_dl - dl0 == ((sel && n >= 24) ? 1 : 0), "R11 data last", 32'(n_dl - dl0), 32'((sel && n >= 24) ? 1 : 0));
      chk(n_sf - sf0 == ((!sel && n > 0) ? 1 : 0), "R11 status first", 32'(n_sf - sf0), 32'((!sel && n > 0) ? 1 : 0));
   endtask

   task automatic do_write(input int n, input logic [7:0] w);
      logic [7:0] expv;
      expv = model_cfg;
      rd_wr = 1'b0;
      tick(2);
      cs_n = 1'b0;
      tick(8);
      for (int k = 0; k < n; k++) begin
         sdi = (k < 8) ? w[7-k] : 1'b1;
         tick(4);
         sck = 1'b0; tick(8);
         sck = 1'b1; tick(4);
         if (k < 8) expv[7-k] = w[7-k];
         if (k == 7) begin
            expv[3] = 1'b0;
            tick(4);
            chk(cfg_o === expv, "R6 commit on eighth bit", 32'(cfg_o), 32'(expv));
         end else begin
            tick(4);
         end
      end
      expv[3] = 1'b0;
      cs_n = 1'b1;
      tick(8);
      chk(cfg_o === expv, (n < 8) ? "R7 short write" : "R6 write", 32'(cfg_o), 32'(expv));
      chk(cfg_o[3] === 1'b0, "R8 reserved low", 32'(cfg_o[3]), 32'd0);
      chk(ctrl_o === cfg_o, "R9 software mode", 32'(ctrl_o), 32'(cfg_o));
      model_cfg = expv;
      rd_wr = 1'b1;
      tick(2);
   endtask

   initial begin
      tick(5);
      // R10 reset values
      chk(cfg_o === 8'hF7, "R10 cfg reset", 32'(cfg_o), 32'hF7);
      chk(sdo_oe === 1'b0 && sdo === 1'b0, "R10 sdo idle", {30'd0, sdo_oe, sdo}, 32'd0);
      rst_n = 1'b1;
      tick(3);
      chk(cfg_o === 8'hF7, "R10 cfg after reset", 32'(cfg_o), 32'hF7);
      chk({rd_data_first, rd_data_last, rd_stat_first} === 3'b000, "R10 pulses idle",
          32'({rd_data_first, rd_data_last, rd_stat_first}), 32'd0);
      model_cfg = 8'hF7;

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][55] == 1'b0)
            do_read(VEC[i][54], int'(VEC[i][53:48]), VEC[i][47:24], VEC[i][23:8], "R1 read bit");
         else
            do_write(int'(VEC[i][53:48]), VEC[i][7:0]);
      end

      // R4: abort after 7 bits, then the re-read starts at the MSB
      do_read(1'b1, 7, 24'hC0FFEE, 16'h0, "R4 first pass");
      do_read(1'b1, 24, 24'hC0FFEE, 16'h0, "R4 re-read");

      // R2: first bit within 4 cycles; a rising edge before any falling edge holds the bit
      data_word = 24'h6A0000; reg_sel = 1'b1; rd_wr = 1'b1;
      sck = 1'b0;
      tick(8);
      cs_n = 1'b0;
      tick(4);
      chk(sdo_oe === 1'b1 && sdo === 1'b0, "R2 first bit latency", {30'd0, sdo_oe, sdo}, 32'd2);
      sck = 1'b1; tick(8);
      chk(sdo === 1'b0, "R2 early rise ignored", 32'(sdo), 32'd0);
      sck = 1'b0; tick(8);
      sck = 1'b1; tick(8);
      chk(sdo === 1'b1, "R2 second bit", 32'(sdo), 32'd1);
      cs_n = 1'b1;
      tick(8);

      // R9 hardware mode
      hw_mode = 1'b1; pin_ctrl = 8'h3C;
      tick(1);
      chk(ctrl_o === 8'h3C, "R9 hardware mode", 32'(ctrl_o), 32'h3C);
      hw_mode = 1'b0;
      tick(1);
      chk(ctrl_o === model_cfg, "R9 back to software", 32'(ctrl_o), 32'(model_cfg));

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog all actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule